// File: doc/BRIEF.md
# Coherent-Read Chained 64-bit Timer

This block is a free-running 64-bit tick counter. It is built from two 32-bit counter stages linked by a carry. The lower stage counts on every enabled clock. The upper stage advances in the same clock edge that the lower stage goes from all-ones to zero. A synchronous load lets the count be set to any value. This is how a test or a boot sequence places the counter close to a rollover.

Software reads the count through a 32-bit register port, so it needs two accesses to get the full value. A read of the low word also copies all 64 bits into a shadow register in the same edge. A later read of the shadowed high word then returns the upper half that matches the low half already returned. The two halves therefore agree even when the lower stage wraps between the two accesses.

A second high-word address returns the live upper half without any latching. On that path a low/high pair taken across a wrap can disagree, which is the torn-read hazard.

Top module: `coherent_timer64`

## Requirements
- R1: A synchronous active-high `rst` clears the count, the shadow register, `rd_data` and `rd_valid` to zero.
- R2: With `cnt_en` high and `load_en` low the count rises by exactly one per clock. With both low the count holds its value.
- R3: When the low word is 0xFFFFFFFF and counting is enabled, the next edge sets the low word to 0 and raises the high word by one in that same edge.
- R4: At all-ones the full 64-bit count wraps to zero on the next enabled edge.
- R5: `load_en` takes priority over `cnt_en`. After an edge with `load_en` high the count equals `load_val`.
- R6: A strobe with `rd_addr`=0 returns the low word of the count as it was at the strobe edge. The data and `rd_valid`=1 appear in the cycle after the strobe. `rd_valid` is high for exactly one cycle per strobe.
- R7: A strobe with `rd_addr`=0 copies the full 64-bit count into the shadow register. A strobe with `rd_addr`=1 returns the shadow's upper 32 bits. The shadow changes only on an address-0 read, so a low-then-high pair always forms one real count value.
- R8: A strobe with `rd_addr`=2 returns the live upper 32 bits at the strobe edge and does not touch the shadow.
- R9: A strobe with `rd_addr`=3 returns zero.
- R10: In a cycle with no strobe, `rd_valid` falls to 0 in the next cycle and `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| load_en | input | 1 | Load the count from `load_val` |
| load_val | input | 64 | Value to load |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 2 | 0 low word + snapshot, 1 shadow high, 2 live high, 3 zero |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
A load, or an enabled count, shows in the count after one edge. A read result is on `rd_data` one edge after its strobe, and it reflects the count as it stood before that edge. The bench drives inputs on the falling edge and samples results on the next falling edge. In this way each check lands exactly one register stage after its cause. The bench's reference count advances on the same rising edges, from the inputs the bench drives. The expected value of a snapshot is taken from that reference at the moment the strobe is driven.

// File: rtl/timer64_pkg.sv
package timer64_pkg;

    localparam int unsigned STAGE_W = 32;
    localparam int unsigned STAGES  = 2;
    localparam int unsigned COUNT_W = STAGE_W * STAGES;

    typedef enum logic [1:0] {
        SEL_LO_SNAP  = 2'd0,
        SEL_HI_SHADE = 2'd1,
        SEL_HI_LIVE  = 2'd2,
        SEL_NONE     = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/count_stage.sv
module count_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         carry
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val   = st_q.cnt;
    assign carry = inc && (st_q.cnt == ALL_ONES);

    // R3: a stage at all-ones that is told to count comes back as zero
    a_r3_stage_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && val == ALL_ONES) |=> (val == '0));

endmodule

// File: rtl/read_port.sv
module read_port
    import timer64_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*W-1:0] count,
    input  logic           stb,
    input  logic [1:0]     addr,
    output logic [W-1:0]   data,
    output logic           valid
);
    typedef struct packed {
        logic [2*W-1:0] shadow;
        logic [W-1:0]   data;
        logic           valid;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d       = rp_q;
        rp_d.valid = stb;
        if (stb) begin
            unique case (rd_sel_e'(addr))
                SEL_LO_SNAP: begin
                    rp_d.data   = count[W-1:0];
                    rp_d.shadow = count;
                end
                SEL_HI_SHADE: rp_d.data = rp_q.shadow[2*W-1:W];
                SEL_HI_LIVE:  rp_d.data = count[2*W-1:W];
                default:      rp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign data  = rp_q.data;
    assign valid = rp_q.valid;

    // R6: every strobe produces one valid cycle right after it
    a_r6_valid_after_stb: assert property (@(posedge clk) disable iff (rst)
        stb |=> valid);
    // R10: no strobe means no valid and unchanged data
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !stb |=> (!valid && $stable(data)));
    // R7: the shadow moves only on a low-word read
    a_r7_shadow_stable: assert property (@(posedge clk) disable iff (rst)
        !(stb && addr == 2'd0) |=> $stable(rp_q.shadow));
    // R7: a high-shadow read returns the shadowed upper half
    a_r7_shade_data: assert property (@(posedge clk) disable iff (rst)
        (stb && addr == 2'd1) |=> (data == rp_q.shadow[2*W-1:W]));

endmodule

// File: rtl/coherent_timer64.sv
module coherent_timer64
    import timer64_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    input  logic               load_en,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               rd_stb,
    input  logic [1:0]         rd_addr,
    output logic [STAGE_W-1:0] rd_data,
    output logic               rd_valid
);
    logic [STAGES:0]        inc_chain;
    logic [COUNT_W-1:0]     count;

    assign inc_chain[0] = cnt_en;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        count_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .inc    (inc_chain[g]),
            .ld     (load_en),
            .ld_val (load_val[g*STAGE_W +: STAGE_W]),
            .val    (count[g*STAGE_W +: STAGE_W]),
            .carry  (inc_chain[g+1])
        );
    end

    read_port #(.W(STAGE_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .stb   (rd_stb),
        .addr  (rd_addr),
        .data  (rd_data),
        .valid (rd_valid)
    );

    // R2: idle count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !load_en) |=> $stable(count));
    // R2: enabled count steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !load_en) |=> (count == $past(count) + 1'b1));
    // R3: low wrap carries into the high word in the same edge
    a_r3_carry: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !load_en && count[STAGE_W-1:0] == '1)
        |=> (count[COUNT_W-1:STAGE_W] == $past(count[COUNT_W-1:STAGE_W]) + 1'b1));
    // R5: load wins over counting
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val)));

endmodule

// File: tb/sim_coherent_timer64.sv
module sim_coherent_timer64;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_val = '0;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    logic [63:0] m_cnt = '0;

    always #2 clk = ~clk;

    coherent_timer64 u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
        .load_val(load_val), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // reference count, from the requirements R1, R2, R4, R5
    always @(posedge clk) begin
        if (rst)          m_cnt <= '0;
        else if (load_en) m_cnt <= load_val;
        else if (cnt_en)  m_cnt <= m_cnt + 64'd1;
    end

    typedef struct packed {
        logic [63:0] pre;
        logic [31:0] n;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{64'h0000_01B9_FFFF_FFF7, 32'd5,  64'h0000_01B9_FFFF_FFFC},
        '{64'h0000_01B9_FFFF_FFF7, 32'd9,  64'h0000_01BA_0000_0000},
        '{64'h0000_01B9_FFFF_FFF7, 32'd20, 64'h0000_01BA_0000_000B},
        '{64'hFFFF_FFFF_FFFF_FFFE, 32'd3,  64'h0000_0000_0000_0001},
        '{64'h0000_0000_FFFF_FFFF, 32'd1,  64'h0000_0001_0000_0000},
        '{64'h0000_0000_0000_0000, 32'd0,  64'h0000_0000_0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
        chk("R6 valid", {63'd0, rd_valid}, 64'd1);
    endtask

    task automatic load(input logic [63:0] v);
        load_en  = 1'b1;
        load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lo, hi, d;
        logic [63:0] snap, prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs cleared
        chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R1 rd_data", {32'd0, rd_data}, 64'd0);
        rd(2'd1, d);
        chk("R1 shadow", {32'd0, d}, 64'd0);
        rd(2'd0, d);
        chk("R1 count", {32'd0, d}, 64'd0);

        // vector table: R3 R4 R7
        foreach (VECS[i]) begin
            load(VECS[i].pre);
            cnt_en = 1'b1;
            repeat (VECS[i].n) @(negedge clk);
            cnt_en = 1'b0;
            rd(2'd0, lo);
            rd(2'd1, hi);
            chk("R3/R4 vector", {hi, lo}, VECS[i].exp);
        end

        // R2: hold with enable low
        load(64'h0000_0005_0000_0010);
        repeat (4) @(negedge clk);
        rd(2'd0, lo);
        chk("R2 hold", {32'd0, lo}, 64'h10);

        // R5: load beats enable
        cnt_en = 1'b1;
        load(64'h0000_0077_0000_1234);
        cnt_en = 1'b0;
        rd(2'd0, lo);
        rd(2'd1, hi);
        chk("R5 load priority", {hi, lo}, 64'h0000_0077_0000_1234);

        // tear vs. coherent across a running wrap: R6 R7 R8
        load(64'h0000_01B9_FFFF_FFF7);
        cnt_en = 1'b1;
        repeat (8) @(negedge clk);
        snap = m_cnt;
        chk("R3 pre-wrap model", snap, 64'h0000_01B9_FFFF_FFFF);
        rd(2'd0, lo);
        chk("R6 low at strobe", {32'd0, lo}, 64'hFFFF_FFFF);
        rd(2'd2, hi);
        chk("R8 live high torn", {32'd0, hi}, 64'h1BA);
        rd(2'd1, hi);
        chk("R7 shadow high", {32'd0, hi}, 64'h1B9);
        rd(2'd3, d);
        chk("R9 unused addr", {32'd0, d}, 64'd0);
        rd(2'd1, hi);
        chk("R8 no shadow change", {32'd0, hi}, 64'h1B9);

        // R7: running latched pairs non-decreasing, matching the model
        load(64'h0000_01B9_FFFF_FFF9);
        prev = '0;
        for (int k = 0; k < 6; k++) begin
            snap = m_cnt;
            rd(2'd0, lo);
            rd(2'd1, hi);
            chk("R7 coherent pair", {hi, lo}, snap);
            chk("R7 non-decreasing", {63'd0, ({hi, lo} >= prev)}, 64'd1);
            prev = {hi, lo};
        end
        cnt_en = 1'b0;

        // R10: idle keeps data, drops valid
        d = rd_data;
        @(negedge clk);
        chk("R10 valid low", {63'd0, rd_valid}, 64'd0);
        chk("R10 data held", {32'd0, rd_data}, {32'd0, d});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule